// File: doc/BRIEF.md
# Pseudo-SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous pseudo-SRAM. Its internal DRAM refresh imposes rules that a plain SRAM does not. The host offers one request at a time through a valid/ready handshake: a read or a write, a 20-bit word address, 16-bit write data and two byte enables. The controller turns each accepted request into a complete bus cycle. It drives the chip-enable, output-enable, write-enable and two byte-select strobes, the address, and the write data with its drive enable. Every interval is a whole number of system clocks.

Reads are paced by chip-enable, and the word read is returned with a one-cycle valid pulse. Writes are paced by the write strobe. Each timing limit is given in nanoseconds together with the clock period. It is converted to clocks by rounding up, with a floor of one clock. The states are `ST_IDLE` (waiting, ready high), `ST_RD_ACCESS` (chip and output enables low for the access time), `ST_WR_SETUP` (chip enable low with output enable high for one clock), `ST_WR_PULSE` (write strobe low, data driven), `ST_WR_PAD` (chip enable kept low until the minimum cycle is covered, skipped when not needed) and `ST_PRECHARGE` (chip enable high, output enable held briefly after a read).

The transitions are as follows:
- An accepted request leaves idle for the read access or the write setup state.
- A read goes to precharge when its timer expires.
- A write goes from setup to pulse, then to pad or directly to precharge.
- Precharge returns to idle.

Top module: `psram_cycle_ctrl`

## Requirements
- R1: Two consecutive falling edges of chip-enable are at least ceil(RC_NS/CLK_NS) clocks apart.
- R2: During a write the write strobe is low for exactly ceil(WP_NS/CLK_NS) clocks. The data bus is driven with the request's write data on every one of those clocks, and the drive enable is low whenever the write strobe is high.
- R3: Chip-enable is high for at least ceil(CP_NS/CLK_NS) clocks before each falling edge.
- R4: While chip-enable and output-enable are both low, both byte selects are low, whatever the request's byte enables. A read returns the full 16-bit word.
- R5: During a write, the lower byte select is low only if req_be[0] is set (DQ[7:0]) and the upper byte select is low only if req_be[1] is set (DQ[15:8]). Only enabled bytes change, so a write with req_be = 00 leaves the word unchanged.
- R6: Output-enable is high whenever the write strobe is low, and also on the clock before the strobe falls.
- R7: Chip-enable never stays low for more than floor(1000/CLK_NS) clocks.
- R8: The device address equals the accepted request address for the whole time chip-enable is low.
- R9: After chip-enable rises, output-enable and write-enable keep their levels for ceil(CHX_NS/CLK_NS) clocks.
- R10: rd_valid is a single-clock pulse. It is observed high exactly ceil(ACC_NS/CLK_NS) clock edges after chip-enable fell for that read, with rd_data equal to the word stored at the address.
- R11: req_ready is high only while no cycle is in progress. Each accepted handshake produces exactly one chip-enable cycle.
- R12: During and right after reset, all strobes and byte selects are high, the data drive enable is low, rd_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| mem_ce_n | output | 1 | Chip-enable, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_addr | output | 20 | Device address |
| mem_dq_out | output | 16 | Data to device |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Data from device |

## Verification
With the default timing, the end of the write strobe, the release of the data bus and the rise of chip-enable all occur on one clock edge, because no pad state is needed. Likewise, read data is captured on the same edge at which chip-enable rises. A modelled memory latches the write on the clock after the strobe rises, using the byte selects seen while the strobe was low. Later reads, compared through the scoreboard, show whether the right bytes were committed. The bench also measures the latency from chip-enable falling to rd_valid on every read, including back-to-back mixed requests, which confirms that capture and precharge entry coincide without losing the word.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_PAD,
        ST_PRECHARGE
    } psram_state_e;

    // nanoseconds to clocks, rounded up, never below one clock
    function automatic int ns_to_clk(input int ns, input int clk_ns);
        int n;
        n = (ns + clk_ns - 1) / clk_ns;
        if (n < 1) n = 1;
        return n;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_tick_timer.sv
module psram_tick_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          expired
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/psram_rd_capture.sv
module psram_rd_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/psram_cycle_ctrl.sv
module psram_cycle_ctrl
    import psram_pkg::*;
#(
    parameter int AW     = 20,
    parameter int DW     = 16,
    parameter int CLK_NS = 8,
    parameter int RC_NS  = 70,
    parameter int ACC_NS = 65,
    parameter int WP_NS  = 45,
    parameter int CP_NS  = 12,
    parameter int CHX_NS = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_be,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int N_RC   = ns_to_clk(RC_NS, CLK_NS);
    localparam int N_ACC  = ns_to_clk(ACC_NS, CLK_NS);
    localparam int N_WP   = ns_to_clk(WP_NS, CLK_NS);
    localparam int N_CP   = ns_to_clk(CP_NS, CLK_NS);
    localparam int N_CHX  = ns_to_clk(CHX_NS, CLK_NS);
    localparam int N_PC   = max2(N_CP, N_CHX + 1);
    localparam int N_RD   = max2(N_ACC, N_RC - N_PC);
    localparam int N_WPAD = max2(0, N_RC - N_PC - 1 - N_WP);
    localparam int N_MAX  = max2(max2(N_RD, N_PC), max2(N_WP, N_WPAD));
    localparam int CW     = $clog2(N_MAX + 1);
    localparam bit HAS_PAD = (N_WPAD > 0);

    localparam logic [CW-1:0] L_RD   = CW'(N_RD - 1);
    localparam logic [CW-1:0] L_CAP  = CW'(N_RD - N_ACC);
    localparam logic [CW-1:0] L_WP   = CW'(N_WP - 1);
    localparam logic [CW-1:0] L_PC   = CW'(N_PC - 1);
    localparam logic [CW-1:0] L_OEHI = CW'(N_PC - 1 - N_CHX);
    localparam logic [CW-1:0] L_PAD  = CW'(HAS_PAD ? N_WPAD - 1 : 0);

    psram_state_e  state_q, state_d;
    logic          tm_load;
    logic [CW-1:0] tm_val, tm_cnt;
    logic          tm_done;
    logic          take;
    logic          last_rd_q;
    logic [1:0]    be_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          capture;

    psram_tick_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tm_val),
        .cnt(tm_cnt), .expired(tm_done)
    );

    psram_rd_capture #(.DW(DW)) u_rcap (
        .clk(clk), .rst_n(rst_n), .capture(capture), .dq_in(mem_dq_in),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign take      = req_ready && req_valid;
    assign capture   = (state_q == ST_RD_ACCESS) && (tm_cnt == L_CAP);

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
            be_q      <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                last_rd_q <= !req_write;
                be_q      <= req_be;
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
            end
        end
    end

    // next state and timer loads
    always_comb begin
        state_d = state_q;
        tm_load = 1'b0;
        tm_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    tm_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tm_val  = L_RD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tm_done) begin
                    state_d = ST_PRECHARGE;
                    tm_load = 1'b1;
                    tm_val  = L_PC;
                end
            end
            ST_WR_SETUP: begin
                state_d = ST_WR_PULSE;
                tm_load = 1'b1;
                tm_val  = L_WP;
            end
            ST_WR_PULSE: begin
                if (tm_done) begin
                    tm_load = 1'b1;
                    if (HAS_PAD) begin
                        state_d = ST_WR_PAD;
                        tm_val  = L_PAD;
                    end else begin
                        state_d = ST_PRECHARGE;
                        tm_val  = L_PC;
                    end
                end
            end
            ST_WR_PAD: begin
                if (tm_done) begin
                    state_d = ST_PRECHARGE;
                    tm_load = 1'b1;
                    tm_val  = L_PC;
                end
            end
            ST_PRECHARGE: begin
                if (tm_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // strobe decode
    always_comb begin
        mem_ce_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_lb_n  = 1'b1;
        mem_ub_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RD_ACCESS: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
                mem_lb_n = 1'b0;
                mem_ub_n = 1'b0;
            end
            ST_WR_SETUP, ST_WR_PAD: begin
                mem_ce_n = 1'b0;
                mem_lb_n = !be_q[0];
                mem_ub_n = !be_q[1];
            end
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_lb_n  = !be_q[0];
                mem_ub_n  = !be_q[1];
                mem_dq_oe = 1'b1;
            end
            ST_PRECHARGE: begin
                mem_oe_n = !(last_rd_q && (tm_cnt > L_OEHI));
            end
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
endmodule

// File: rtl/psram_cycle_ctrl_chk.sv
module psram_cycle_ctrl_chk
    import psram_pkg::*;
#(
    parameter int CLK_NS = 8,
    parameter int RC_NS  = 70,
    parameter int WP_NS  = 45,
    parameter int CP_NS  = 12
) (
    input logic clk,
    input logic rst_n,
    input logic mem_ce_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_lb_n,
    input logic mem_ub_n,
    input logic mem_dq_oe,
    input logic rd_valid
);
    localparam logic [7:0] C_RC    = 8'(ns_to_clk(RC_NS, CLK_NS));
    localparam logic [7:0] C_WP    = 8'(ns_to_clk(WP_NS, CLK_NS));
    localparam logic [7:0] C_CP    = 8'(ns_to_clk(CP_NS, CLK_NS));
    localparam logic [7:0] C_CEMAX = 8'(1000 / CLK_NS);

    logic [7:0] ce_lo, ce_hi, we_lo, since_fall;
    logic       ce_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_lo      <= '0;
            ce_hi      <= 8'hFF;
            we_lo      <= '0;
            since_fall <= 8'hFF;
            ce_prev    <= 1'b1;
        end else begin
            ce_prev    <= mem_ce_n;
            ce_lo      <= mem_ce_n ? 8'd0 : ((ce_lo == 8'hFF) ? ce_lo : ce_lo + 8'd1);
            ce_hi      <= !mem_ce_n ? 8'd0 : ((ce_hi == 8'hFF) ? ce_hi : ce_hi + 8'd1);
            we_lo      <= mem_we_n ? 8'd0 : ((we_lo == 8'hFF) ? we_lo : we_lo + 8'd1);
            since_fall <= (ce_prev && !mem_ce_n) ? 8'd1
                        : ((since_fall == 8'hFF) ? since_fall : since_fall + 8'd1);
        end
    end

    p_cycle_min_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> since_fall >= C_RC);
    p_strobe_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> we_lo == C_WP);
    p_dq_in_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> !mem_we_n);
    p_ce_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> ce_hi >= C_CP);
    p_read_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_oe_n) |-> (!mem_lb_n && !mem_ub_n));
    p_oe_off_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    p_oe_before_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_oe_n));
    p_ce_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> ce_lo < C_CEMAX);
    p_quiet_after_ce_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |=> ($stable(mem_oe_n) && $stable(mem_we_n)));
    p_rdv_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

bind psram_cycle_ctrl psram_cycle_ctrl_chk #(
    .CLK_NS(CLK_NS), .RC_NS(RC_NS), .WP_NS(WP_NS), .CP_NS(CP_NS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_oe(mem_dq_oe), .rd_valid(rd_valid)
);

// File: tb/psram_cycle_ctrl_test.sv
module psram_cycle_ctrl_test;
    localparam int B_RC    = (70 + 7) / 8;
    localparam int B_ACC   = (65 + 7) / 8;
    localparam int B_WP    = (45 + 7) / 8;
    localparam int B_CP    = (12 + 7) / 8;
    localparam int B_CHX   = (10 + 7) / 8;
    localparam int B_CEMAX = 1000 / 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [19:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;

    int checks = 0;
    int errors = 0;
    int accepts = 0;
    int ce_falls = 0;
    bit done = 1'b0;

    logic [15:0] model_mem [256];
    logic [15:0] shadow [256];
    logic [15:0] exp_q [$];
    logic [19:0] last_addr;
    logic [15:0] last_wdata;

    psram_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #4 clk = ~clk;

    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model_mem[mem_addr[7:0]] : 16'hDEAD;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // memory model: latch while strobe low, commit once it is high again
    bit          pend = 1'b0;
    logic [19:0] pend_a;
    logic [15:0] pend_d;
    logic        pend_lb, pend_ub;
    always @(negedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            pend = 1'b1; pend_a = mem_addr; pend_d = mem_dq_out;
            pend_lb = mem_lb_n; pend_ub = mem_ub_n;
        end else if (pend && mem_we_n) begin
            if (!pend_lb) model_mem[pend_a[7:0]][7:0]  = pend_d[7:0];
            if (!pend_ub) model_mem[pend_a[7:0]][15:8] = pend_d[15:8];
            pend = 1'b0;
        end
    end

    // monitor
    bit   p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1;
    int   ce_lo = 0, ce_hi = 1000, we_lo = 0, since_fall = 1000, chx_left = 0;
    bit   bytes_ok = 1'b1, addr_ok = 1'b1, dq_ok = 1'b1, busy_ok = 1'b1, seen_rd = 1'b0;
    logic oe_at, we_at;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ce && !mem_ce_n) begin
                ce_falls++;
                chk(ce_hi >= B_CP, "R3 ce high gap", ce_hi, B_CP);
                if (ce_falls > 1) chk(since_fall >= B_RC, "R1 cycle start-to-start", since_fall, B_RC);
                chk(mem_addr == last_addr, "R8 address at ce fall", mem_addr, last_addr);
                since_fall = 0; ce_lo = 0;
                bytes_ok = 1'b1; addr_ok = 1'b1; busy_ok = 1'b1; seen_rd = 1'b0;
            end else since_fall++;
            if (!mem_ce_n) begin
                ce_lo++;
                if (mem_addr != last_addr) addr_ok = 1'b0;
                if (req_ready) busy_ok = 1'b0;
                if (!mem_oe_n) begin
                    seen_rd = 1'b1;
                    if (mem_lb_n || mem_ub_n) bytes_ok = 1'b0;
                end
            end else ce_hi++;
            if (!p_ce && mem_ce_n) begin
                chk(ce_lo <= B_CEMAX, "R7 ce low length", ce_lo, B_CEMAX);
                chk(addr_ok, "R8 address stable", addr_ok, 1);
                chk(busy_ok, "R11 ready low while busy", busy_ok, 1);
                if (seen_rd) chk(bytes_ok, "R4 byte selects low on read", bytes_ok, 1);
                ce_hi = 1; oe_at = mem_oe_n; we_at = mem_we_n; chx_left = B_CHX - 1;
            end else if (chx_left > 0) begin
                chx_left--;
                chk(mem_oe_n == oe_at && mem_we_n == we_at, "R9 strobes quiet after ce rise",
                    {mem_oe_n, mem_we_n}, {oe_at, we_at});
            end
            if (p_we && !mem_we_n) begin
                chk(p_oe && mem_oe_n, "R6 oe high at strobe fall", {p_oe, mem_oe_n}, 3);
                we_lo = 0; dq_ok = 1'b1;
            end
            if (!mem_we_n) begin
                we_lo++;
                if (!mem_dq_oe || mem_dq_out != last_wdata) dq_ok = 1'b0;
            end else if (mem_dq_oe) dq_ok = 1'b0;
            if (!p_we && mem_we_n) begin
                chk(we_lo == B_WP, "R2 strobe width", we_lo, B_WP);
                chk(dq_ok, "R2 data driven only in strobe", dq_ok, 1);
            end
            if (rd_valid) begin
                chk(since_fall == B_ACC, "R10 read latency", since_fall, B_ACC);
                if (exp_q.size() == 0) chk(1'b0, "R10 unexpected rd_valid", 1, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R10 read data", rd_data, e);
                end
            end
        end
        p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n;
    end

    // driver
    task automatic do_req(input bit wr, input logic [19:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        last_addr = a; last_wdata = d;
        accepts++;
        if (wr) begin
            if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
            if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
        end else exp_q.push_back(shadow[a[7:0]]);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            model_mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
            shadow[i]    = 16'(i * 16'h0101) ^ 16'h5A5A;
        end
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
            "R12 strobes idle in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rd_valid && mem_ce_n && !mem_dq_oe, "R12 state after reset",
            {req_ready, rd_valid, mem_ce_n}, 3'b101);

        do_req(1'b0, 20'hABC12, '0, 2'b00);          // R10 untouched word
        do_req(1'b1, 20'h00005, 16'hA5C3, 2'b11);    // R5 full word
        do_req(1'b0, 20'h00005, '0, 2'b11);
        do_req(1'b1, 20'h00005, 16'h1177, 2'b10);    // R5 upper only
        do_req(1'b0, 20'h00005, '0, 2'b01);          // R4 be ignored on read
        do_req(1'b1, 20'h00005, 16'h4499, 2'b01);    // R5 lower only
        do_req(1'b0, 20'h00005, '0, 2'b10);
        do_req(1'b1, 20'h00005, 16'hFFFF, 2'b00);    // R5 no byte enabled
        do_req(1'b0, 20'h00005, '0, 2'b00);
        do_req(1'b1, 20'hFFFFF, 16'hBEEF, 2'b11);    // R8 address extremes
        do_req(1'b1, 20'h00000, 16'h0F0F, 2'b11);
        do_req(1'b0, 20'hFFFFF, '0, 2'b11);
        do_req(1'b0, 20'h00000, '0, 2'b11);
        for (int i = 0; i < 8; i++)                  // back-to-back mixed traffic
            do_req(i[0], 20'h01000 + 20'(i * 37), 16'(i * 16'h1357), 2'b11);
        for (int i = 0; i < 8; i++)
            do_req(1'b0, 20'h01000 + 20'(i * 37), '0, 2'b11);

        repeat (40) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
        chk(ce_falls == accepts, "R11 one cycle per request", ce_falls, accepts);
        chk(req_ready && mem_ce_n, "R11 ready when idle", req_ready, 1);
        done = 1'b1;
        summary();
    end
endmodule